// File: doc/BRIEF.md
# Three-Way Prioritised Bus Crossbar

This block joins three bus masters (a DMA engine, a host port and a CPU) to three targets (on-chip memory, a peripheral bus and an external-memory port). Each master presents a single-beat request made of a target select, an address, a write flag and write data. Masters that address different targets are all served in the same cycle. Each target has its own arbiter, and the arbiters work in parallel. When several masters address one target, a fixed ranking picks the winner: DMA first, then host, then CPU.

Some paths are left out on purpose. The host has no route to the peripheral target, and select code 3 names no target at all. A request on a missing path is still accepted in its cycle. It reaches no target and is answered one cycle later with an error pulse. A master that loses arbitration holds its request, with address and data unchanged, until it is granted. Every accepted transfer completes in the cycle after its grant. A read returns its data together with a valid pulse.

The target interface carries a one-cycle strobe per target, along with the winner's address, write flag, write data and master index. A target returns its read data in the cycle after its strobe.

Top module: `prio_xbar`

## Requirements
- R1: After reset, with no requests, all grant, completion, error, read-valid and target-strobe outputs are 0.
- R2: When the masters select pairwise different reachable targets, every one of them is granted in the same cycle and every addressed target strobes.
- R3: Masters are numbered DMA=0, host=1, CPU=2. When several masters select one target, only the lowest-numbered one is granted, and the target's master index output shows that number.
- R4: Target selects are memory=0, peripheral=1, external=2. The path from the host to select 1, and select 3 from any master, are unsupported. Such a request is granted but strobes no target, and it does not block other masters.
- R5: A request on an unsupported path gives a one-cycle error pulse in the cycle after its grant, with no completion and no read-valid.
- R6: A granted read gives a completion pulse and a read-valid pulse in the next cycle. The read data is the value the selected target returns in that cycle.
- R7: For a granted write, the target strobe carries the winner's address, write data and a write flag of 1. The next cycle gives a completion pulse without read-valid.
- R8: A master that loses arbitration gets no grant and no response while a higher-ranked master holds the target. It is granted in the first cycle that no higher-ranked master requests that target.
- R9: Contention on one target does not delay a master that selects a different target in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_req | input | NM | Request per master |
| m_tsel | input | NM*TSW | Target select per master |
| m_addr | input | NM*AW | Address per master |
| m_we | input | NM | Write flag per master |
| m_wdata | input | NM*DW | Write data per master |
| m_gnt | output | NM | Request accepted this cycle |
| m_done | output | NM | Successful completion, one cycle after grant |
| m_err | output | NM | Error response, one cycle after grant |
| m_rvalid | output | NM | Read data valid |
| m_rdata | output | NM*DW | Read data per master |
| t_req | output | NT | Transfer strobe per target |
| t_src | output | NT*MIW | Index of the master owning each target |
| t_addr | output | NT*AW | Address per target |
| t_we | output | NT | Write flag per target |
| t_wdata | output | NT*DW | Write data per target |
| t_rdata | input | NT*DW | Read data per target, one cycle after strobe |

## Verification
Two functions can fall in the same cycle: arbitration on a contested target, and either a parallel grant or an error acceptance on another path. The bench provokes this in two ways. DMA and CPU contend for memory while the host reaches the external port. The host also tries the peripheral target while the CPU addresses it legally. It then checks, before the clock edge, the grant vector and each target's owner index. After the edge it checks that each master received exactly its own kind of response: data, completion, error or nothing.

// File: rtl/pxb_pkg.sv
package pxb_pkg;

  // Master ranking: a lower index wins contention.
  localparam int MST_DMA  = 0;
  localparam int MST_HOST = 1;
  localparam int MST_CPU  = 2;

  // Bit m*nt+t of the map is set when master m may reach target t.
  function automatic logic conn_ok(input logic [63:0] map, input int nt,
                                   input int m, input int t);
    if (t >= nt) return 1'b0;
    return map[m*nt + t];
  endfunction

endpackage

// File: rtl/pxb_arb.sv
module pxb_arb #(
  parameter int NM  = 3,
  parameter int MIW = 2
) (
  input  logic [NM-1:0]  req,
  output logic [NM-1:0]  gnt,
  output logic           busy,
  output logic [MIW-1:0] owner
);
  logic found;

  always_comb begin
    gnt   = '0;
    owner = '0;
    found = 1'b0;
    for (int i = 0; i < NM; i++) begin
      if (req[i] && !found) begin
        gnt[i] = 1'b1;
        owner  = MIW'(i);
        found  = 1'b1;
      end
    end
    busy = found;
  end
endmodule

// File: rtl/pxb_resp.sv
module pxb_resp #(
  parameter int NT  = 3,
  parameter int TSW = 2,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acc_ok,
  input  logic           acc_bad,
  input  logic           we,
  input  logic [TSW-1:0] tsel,
  input  logic [NT*DW-1:0] t_rdata,
  output logic           done,
  output logic           err,
  output logic           rvalid,
  output logic [DW-1:0]  rdata
);
  logic           rd_q;
  logic [TSW-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done  <= 1'b0;
      err   <= 1'b0;
      rd_q  <= 1'b0;
      sel_q <= '0;
    end else begin
      done  <= acc_ok;
      err   <= acc_bad;
      rd_q  <= acc_ok && !we;
      sel_q <= tsel;
    end
  end

  assign rvalid = rd_q;

  always_comb begin
    rdata = '0;
    for (int t = 0; t < NT; t++)
      if (rd_q && sel_q == TSW'(t)) rdata = t_rdata[t*DW +: DW];
  end
endmodule

// File: rtl/prio_xbar.sv
module prio_xbar
  import pxb_pkg::*;
#(
  parameter int NM  = 3,
  parameter int NT  = 3,
  parameter int TSW = 2,
  parameter int AW  = 16,
  parameter int DW  = 32,
  parameter logic [NM*NT-1:0] CONN = 9'b111_101_111,
  localparam int MIW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NM-1:0]     m_req,
  input  logic [NM*TSW-1:0] m_tsel,
  input  logic [NM*AW-1:0]  m_addr,
  input  logic [NM-1:0]     m_we,
  input  logic [NM*DW-1:0]  m_wdata,
  output logic [NM-1:0]     m_gnt,
  output logic [NM-1:0]     m_done,
  output logic [NM-1:0]     m_err,
  output logic [NM-1:0]     m_rvalid,
  output logic [NM*DW-1:0]  m_rdata,
  output logic [NT-1:0]     t_req,
  output logic [NT*MIW-1:0] t_src,
  output logic [NT*AW-1:0]  t_addr,
  output logic [NT-1:0]     t_we,
  output logic [NT*DW-1:0]  t_wdata,
  input  logic [NT*DW-1:0]  t_rdata
);
  // Named internal events for the checker.
  logic [NM-1:0]     path_ok_w;   // request on a supported path
  logic [NM-1:0]     bad_w;       // request on an unsupported path
  logic [NM-1:0]     win_w;       // won some target this cycle
  logic [NT*NM-1:0]  hit_w;       // bit t*NM+m: master m wants target t
  logic [NT*NM-1:0]  tgt_gnt;     // bit t*NM+m: target t granted to m
  logic [NT-1:0]     busy_w;
  logic [NT*MIW-1:0] owner_w;

  for (genvar m = 0; m < NM; m++) begin : g_mreq
    assign path_ok_w[m] = m_req[m] &&
      conn_ok(64'(CONN), NT, m, int'(m_tsel[m*TSW +: TSW]));
    assign bad_w[m] = m_req[m] && !path_ok_w[m];
  end

  for (genvar t = 0; t < NT; t++) begin : g_tgt
    for (genvar m = 0; m < NM; m++) begin : g_hit
      assign hit_w[t*NM + m] = path_ok_w[m] &&
                               (m_tsel[m*TSW +: TSW] == TSW'(t));
    end

    pxb_arb #(.NM(NM), .MIW(MIW)) u_arb (
      .req   (hit_w[t*NM +: NM]),
      .gnt   (tgt_gnt[t*NM +: NM]),
      .busy  (busy_w[t]),
      .owner (owner_w[t*MIW +: MIW])
    );

    always_comb begin
      t_req[t]               = busy_w[t];
      t_src[t*MIW +: MIW]    = owner_w[t*MIW +: MIW];
      t_addr[t*AW +: AW]     = '0;
      t_we[t]                = 1'b0;
      t_wdata[t*DW +: DW]    = '0;
      for (int m = 0; m < NM; m++) begin
        if (tgt_gnt[t*NM + m]) begin
          t_addr[t*AW +: AW]  = m_addr[m*AW +: AW];
          t_we[t]             = m_we[m];
          t_wdata[t*DW +: DW] = m_wdata[m*DW +: DW];
        end
      end
    end
  end

  always_comb begin
    for (int m = 0; m < NM; m++) begin
      win_w[m] = 1'b0;
      for (int t = 0; t < NT; t++) win_w[m] = win_w[m] | tgt_gnt[t*NM + m];
    end
  end

  assign m_gnt = win_w | bad_w;

  for (genvar m = 0; m < NM; m++) begin : g_resp
    pxb_resp #(.NT(NT), .TSW(TSW), .DW(DW)) u_resp (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc_ok  (win_w[m]),
      .acc_bad (bad_w[m]),
      .we      (m_we[m]),
      .tsel    (m_tsel[m*TSW +: TSW]),
      .t_rdata (t_rdata),
      .done    (m_done[m]),
      .err     (m_err[m]),
      .rvalid  (m_rvalid[m]),
      .rdata   (m_rdata[m*DW +: DW])
    );
  end
endmodule

// File: rtl/pxb_chk.sv
module pxb_chk #(
  parameter int NM  = 3,
  parameter int NT  = 3,
  parameter int TSW = 2,
  parameter int MIW = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NM-1:0]     m_req,
  input logic [NM*TSW-1:0] m_tsel,
  input logic [NM-1:0]     m_gnt,
  input logic [NM-1:0]     m_done,
  input logic [NM-1:0]     m_err,
  input logic [NT-1:0]     t_req,
  input logic [NT*MIW-1:0] t_src,
  input logic [NM-1:0]     bad_w,
  input logic [NT*NM-1:0]  tgt_gnt
);
  for (genvar t = 0; t < NT; t++) begin : g_t
    assert_single_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tgt_gnt[t*NM +: NM]));
  end

  for (genvar m = 0; m < NM; m++) begin : g_m
    assert_err_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bad_w[m] |=> (m_err[m] && !m_done[m]));
    assert_done_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (m_gnt[m] && !bad_w[m]) |=> (m_done[m] && !m_err[m]));
  end

  assert_dma_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    m_req[0] |-> m_gnt[0]);

  if (NM > 2) begin : g_cpu
    assert_cpu_yields_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req[0] && !bad_w[0] && m_req[2] &&
       m_tsel[0 +: TSW] == m_tsel[2*TSW +: TSW]) |-> !m_gnt[2]);
  end

  if (NT > 1 && NM > 1) begin : g_hp
    assert_host_no_periph_R4: assert property (@(posedge clk) disable iff (!rst_n)
      t_req[1] |-> (t_src[MIW +: MIW] != MIW'(1)));
  end
endmodule

bind prio_xbar pxb_chk #(.NM(NM), .NT(NT), .TSW(TSW), .MIW(MIW)) u_chk (
  .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_tsel(m_tsel), .m_gnt(m_gnt),
  .m_done(m_done), .m_err(m_err), .t_req(t_req), .t_src(t_src),
  .bad_w(bad_w), .tgt_gnt(tgt_gnt)
);

// File: tb/prio_xbar_test.sv
module prio_xbar_test;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 3, NT = 3, TSW = 2, AW = 16, DW = 32, MIW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NM-1:0]     m_req = '0;
  logic [NM*TSW-1:0] m_tsel = '0;
  logic [NM*AW-1:0]  m_addr = '0;
  logic [NM-1:0]     m_we = '0;
  logic [NM*DW-1:0]  m_wdata = '0;
  logic [NM-1:0]     m_gnt, m_done, m_err, m_rvalid;
  logic [NM*DW-1:0]  m_rdata;
  logic [NT-1:0]     t_req, t_we;
  logic [NT*MIW-1:0] t_src;
  logic [NT*AW-1:0]  t_addr;
  logic [NT*DW-1:0]  t_wdata;
  logic [NT*DW-1:0]  t_rdata = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_xbar uut (
    .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_tsel(m_tsel), .m_addr(m_addr),
    .m_we(m_we), .m_wdata(m_wdata), .m_gnt(m_gnt), .m_done(m_done),
    .m_err(m_err), .m_rvalid(m_rvalid), .m_rdata(m_rdata), .t_req(t_req),
    .t_src(t_src), .t_addr(t_addr), .t_we(t_we), .t_wdata(t_wdata),
    .t_rdata(t_rdata)
  );

  // Target model: registered read data that encodes target and address.
  function automatic logic [DW-1:0] exp_rd(input int t, input logic [AW-1:0] a);
    return {8'hA5, 6'd0, 2'(t), a};
  endfunction

  always @(posedge clk) begin
    for (int t = 0; t < NT; t++)
      if (t_req[t] && !t_we[t])
        t_rdata[t*DW +: DW] <= exp_rd(t, t_addr[t*AW +: AW]);
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_m(input int m, input bit req, input int tsel,
                       input logic [AW-1:0] a, input bit we, input logic [DW-1:0] d);
    m_req[m] = req;
    m_tsel[m*TSW +: TSW] = TSW'(tsel);
    m_addr[m*AW +: AW] = a;
    m_we[m] = we;
    m_wdata[m*DW +: DW] = d;
  endtask

  task automatic idle_all();
    for (int m = 0; m < NM; m++) set_m(m, 0, 0, '0, 0, '0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 gnt", m_gnt, 0);
    chk("R1 resp", {m_done, m_err, m_rvalid}, 0);
    chk("R1 treq", t_req, 0);
  endtask

  task automatic t_parallel();
    @(negedge clk);
    set_m(0, 1, 0, 16'h0010, 0, '0);
    set_m(1, 1, 2, 16'h0020, 0, '0);
    set_m(2, 1, 1, 16'h0030, 0, '0);
    #1;
    chk("R2 all granted", m_gnt, 3'b111);
    chk("R2 all strobed", t_req, 3'b111);
    chk("R2 owners", t_src, {2'd1, 2'd2, 2'd0});
    @(posedge clk); #1;
    idle_all();
    chk("R6 rvalid", m_rvalid, 3'b111);
    chk("R6 done", m_done, 3'b111);
    chk("R6 dma data", m_rdata[0 +: DW], exp_rd(0, 16'h0010));
    chk("R6 host data", m_rdata[DW +: DW], exp_rd(2, 16'h0020));
    chk("R6 cpu data", m_rdata[2*DW +: DW], exp_rd(1, 16'h0030));
  endtask

  task automatic t_contend();
    @(negedge clk);
    set_m(0, 1, 0, 16'h0101, 0, '0);
    set_m(1, 1, 0, 16'h0202, 0, '0);
    set_m(2, 1, 0, 16'h0303, 0, '0);
    #1;
    chk("R3 dma wins", m_gnt, 3'b001);
    chk("R3 owner dma", t_src[1:0], 2'd0);
    chk("R3 addr dma", t_addr[AW-1:0], 16'h0101);
    @(posedge clk); #1;
    chk("R3 dma rvalid", m_rvalid, 3'b001);
    chk("R3 dma data", m_rdata[0 +: DW], exp_rd(0, 16'h0101));
    @(negedge clk);
    set_m(0, 0, 0, '0, 0, '0);
    #1;
    chk("R8 host next", m_gnt, 3'b010);
    chk("R3 owner host", t_src[1:0], 2'd1);
    @(posedge clk); #1;
    chk("R8 host rvalid", m_rvalid, 3'b010);
    @(negedge clk);
    set_m(1, 0, 0, '0, 0, '0);
    #1;
    chk("R8 cpu last", m_gnt, 3'b100);
    @(posedge clk); #1;
    idle_all();
    chk("R8 cpu rvalid", m_rvalid, 3'b100);
    chk("R8 cpu data", m_rdata[2*DW +: DW], exp_rd(0, 16'h0303));
  endtask

  task automatic t_host_over_cpu();
    @(negedge clk);
    set_m(1, 1, 2, 16'h0A0A, 0, '0);
    set_m(2, 1, 2, 16'h0B0B, 0, '0);
    #1;
    chk("R3 host beats cpu", m_gnt, 3'b010);
    chk("R3 ext owner", t_src[5:4], 2'd1);
    @(posedge clk); #1;
    chk("R8 cpu no resp", {m_done[2], m_rvalid[2], m_err[2]}, 0);
    @(negedge clk);
    idle_all();
  endtask

  task automatic t_write();
    @(negedge clk);
    set_m(2, 1, 1, 16'h0044, 1, 32'hDEADBEEF);
    #1;
    chk("R7 strobe", {t_req, t_we}, {3'b010, 3'b010});
    chk("R7 addr", t_addr[AW +: AW], 16'h0044);
    chk("R7 wdata", t_wdata[DW +: DW], 32'hDEADBEEF);
    @(posedge clk); #1;
    idle_all();
    chk("R7 done no rvalid", {m_done, m_rvalid}, {3'b100, 3'b000});
  endtask

  task automatic t_noconn();
    @(negedge clk);
    set_m(1, 1, 1, 16'h0055, 0, '0);
    set_m(2, 1, 1, 16'h0066, 0, '0);
    #1;
    chk("R4 both accepted", m_gnt, 3'b110);
    chk("R4 periph owner cpu", {t_req, t_src[3:2]}, {3'b010, 2'd2});
    @(posedge clk); #1;
    idle_all();
    chk("R5 host err", {m_err, m_done}, {3'b010, 3'b100});
    chk("R5 host no rvalid", m_rvalid, 3'b100);
    @(negedge clk);
    set_m(0, 1, 3, 16'h0077, 0, '0);
    #1;
    chk("R4 sel3 no strobe", {m_gnt, t_req}, {3'b001, 3'b000});
    @(posedge clk); #1;
    idle_all();
    chk("R5 dma err", {m_err, m_done, m_rvalid}, {3'b001, 3'b000, 3'b000});
    @(posedge clk); #1;
    chk("R5 single pulse", m_err, 0);
  endtask

  task automatic t_independent();
    @(negedge clk);
    set_m(0, 1, 0, 16'h0111, 0, '0);
    set_m(2, 1, 0, 16'h0222, 0, '0);
    set_m(1, 1, 2, 16'h0333, 0, '0);
    #1;
    chk("R9 host unaffected", m_gnt, 3'b011);
    @(posedge clk); #1;
    chk("R9 host data", m_rdata[DW +: DW], exp_rd(2, 16'h0333));
    @(negedge clk);
    idle_all();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_parallel();
    t_contend();
    t_host_over_cpu();
    t_write();
    t_noconn();
    t_independent();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule